// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds two 32-bit IEEE-754 single-precision words and returns their single-precision sum. A caller places both operands and a rounding choice on the inputs and pulses `start`. The block takes the request only while it is idle. Four clock edges later it raises `done` for exactly one cycle, with the sum on `sum_o` in that same cycle. The sum then stays on `sum_o` until the next operation finishes.

The work is split over three register stages:

- **Alignment stage.** It unpacks both words and restores the hidden bit of normal operands. It shifts the operand with the smaller exponent right, and any bits that fall off the end collapse into a sticky bit.
- **Combine stage.** It two's-complements a negative mantissa, adds the two mantissas, and converts a negative total back to sign and magnitude.
- **Normalise stage.** It normalises the magnitude, then rounds or truncates it to 23 fraction bits.

NaN, infinity, signed zero and subnormal operands are resolved in the alignment stage.

Top module: `fp32_add_seq`

## Requirements
- R1: A word is read as sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0. Operands with an exponent field of 1 to 254 have a hidden leading 1 restored before the add (1.0 + 2.0 = 0x40400000).
- R2: When the exponents differ, the smaller operand's mantissa is shifted right by the exponent difference, and the result starts from the larger exponent (9.25 + 4.625 = 0x415E0000).
- R3: Operands of opposite sign are combined in two's complement. A negative total is complemented back, and the result sign becomes 1 (1.0 + -3.0 = 0xC0000000).
- R4: A carry out of the hidden position shifts the mantissa right and raises the exponent by one. Cancellation shifts the mantissa left and lowers the exponent by the shift count (1.0 + 0xBF7FFFFF = 0x33800000).
- R5: When `rnd_even` is 1, the sum is rounded to nearest with ties to an even fraction. When it is 0, excess bits are dropped, which truncates toward zero. In both modes the result is the exact sum rounded that way.
- R6: Any NaN operand (exponent field 255 with a nonzero fraction) yields 0x7FC00000. Infinities of opposite sign also yield 0x7FC00000.
- R7: An infinite operand (exponent field 255 with a zero fraction) added to a finite one returns that infinity. A sum whose exponent would exceed 254 returns infinity with the result sign, in both rounding modes.
- R8: An operand with a zero exponent field and a nonzero fraction is subnormal: it has no hidden bit and an effective exponent of 1. A result below the smallest normal is returned as a subnormal with the correct sign.
- R9: Exact cancellation of nonzero operands returns +0 (0x00000000). The sum of two zeros is negative only when both zeros are negative.
- R10: `start` is accepted only while idle, and is ignored while an operation is in flight. `done` is high for exactly one cycle, four clock edges after the accepting edge, with the result valid in that cycle.
- R11: While reset is applied, `done` is 0 and `sum_o` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request strobe, taken when idle |
| rnd_even | input | 1 | 1 = round to nearest even, 0 = truncate |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| sum_o | output | 32 | Sum word, valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted alignment or sticky bit shows up as a sum that is off by one unit in the last place, or as a wrongly broken tie. It appears in the `done` cycle of that very operation, four edges after `start`, so sums are compared against an exact wide-integer model across both rounding modes and random operands. A wrong sign or mis-steered special case shows as a wrong sign bit, NaN or infinity word in that same cycle. A sequencer fault shows at the ports as a `done` that is missing, late, doubled, or caused by a `start` that should have been ignored.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned MAN_W  = FRAC_W + 1;
  localparam int unsigned GRS_W  = 3;
  localparam int unsigned EXT_W  = MAN_W + GRS_W;
  localparam int unsigned SUM_W  = EXT_W + 2;
  localparam int unsigned EXPI_W = EXP_W + 2;
  localparam int unsigned LZ_W   = $clog2(EXT_W + 1);

  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t QNAN = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [EXP_W-1:0] exp_of(word_t w);
    return w[WORD_W-2 -: EXP_W];
  endfunction

  function automatic logic [FRAC_W-1:0] frac_of(word_t w);
    return w[FRAC_W-1:0];
  endfunction

  function automatic logic is_nan(word_t w);
    return (exp_of(w) == EXP_MAX) && (frac_of(w) != '0);
  endfunction

  function automatic logic is_inf(word_t w);
    return (exp_of(w) == EXP_MAX) && (frac_of(w) == '0);
  endfunction

  // aligned operand pair, big = larger exponent
  typedef struct packed {
    logic             special;
    word_t            spec_word;
    logic             sign_big;
    logic             sign_small;
    logic [EXP_W-1:0] exp_big;
    logic [EXT_W-1:0] man_big;
    logic [EXT_W-1:0] man_small;
  } aln_t;

  // signed-magnitude sum before normalisation
  typedef struct packed {
    logic             special;
    word_t            spec_word;
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [EXT_W:0]   mag;
  } cmb_t;
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  word_t op_a,
  input  word_t op_b,
  output aln_t  aln
);
  word_t            ops [2];
  logic [1:0]       sgn, nan, inf, zer;
  logic [EXP_W-1:0] eff [2];
  logic [MAN_W-1:0] man [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  // identical field decode for both operands
  for (genvar k = 0; k < 2; k++) begin : g_unpack
    assign sgn[k] = ops[k][WORD_W-1];
    assign nan[k] = is_nan(ops[k]);
    assign inf[k] = is_inf(ops[k]);
    assign zer[k] = (ops[k][WORD_W-2:0] == '0);
    // subnormal: effective exponent 1, no hidden bit
    assign eff[k] = (exp_of(ops[k]) == '0) ? EXP_W'(1) : exp_of(ops[k]);
    assign man[k] = {exp_of(ops[k]) != '0, frac_of(ops[k])};
  end

  logic               bi, si;
  logic [EXP_W-1:0]   diff, dcap;
  logic [2*EXT_W-1:0] wide;

  always_comb begin
    bi   = (eff[1] > eff[0]);
    si   = ~bi;
    diff = eff[bi] - eff[si];
    dcap = (diff > EXP_W'(EXT_W)) ? EXP_W'(EXT_W) : diff;
    // bits shifted below the window collapse into the sticky position
    wide = {man[si], {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> dcap;

    aln.man_small  = wide[2*EXT_W-1:EXT_W] | EXT_W'(|wide[EXT_W-1:0]);
    aln.man_big    = {man[bi], {GRS_W{1'b0}}};
    aln.exp_big    = eff[bi];
    aln.sign_big   = sgn[bi];
    aln.sign_small = sgn[si];

    aln.special   = 1'b1;
    aln.spec_word = '0;
    if ((|nan) || ((&inf) && (sgn[0] != sgn[1]))) aln.spec_word = QNAN;
    else if (inf[0])                               aln.spec_word = op_a;
    else if (inf[1])                               aln.spec_word = op_b;
    else if (&zer)  aln.spec_word = {sgn[0] & sgn[1], {(WORD_W-1){1'b0}}};
    else                                           aln.special   = 1'b0;
  end
endmodule

// File: rtl/fpa_combine.sv
module fpa_combine
  import fpa_pkg::*;
(
  input  aln_t aln,
  output cmb_t cmb
);
  logic [SUM_W-1:0] xb, xs, tb, ts, s;
  logic             neg;

  always_comb begin
    xb  = {2'b00, aln.man_big};
    xs  = {2'b00, aln.man_small};
    // negative operand enters as its two's complement
    tb  = aln.sign_big   ? (~xb + SUM_W'(1)) : xb;
    ts  = aln.sign_small ? (~xs + SUM_W'(1)) : xs;
    s   = tb + ts;
    neg = s[SUM_W-1];

    cmb.special   = aln.special;
    cmb.spec_word = aln.spec_word;
    cmb.exp       = aln.exp_big;
    cmb.sign      = neg;
    // negative total returns to sign-magnitude
    cmb.mag       = neg ? (EXT_W+1)'(~s + SUM_W'(1)) : s[EXT_W:0];
  end
endmodule

// File: rtl/fpa_round.sv
module fpa_round
  import fpa_pkg::*;
(
  input  cmb_t  cmb,
  input  logic  rne,
  output word_t word
);
  logic [LZ_W-1:0]   lz;
  logic              found;
  logic [EXPI_W-1:0] e, lim, sh, fld;
  logic [EXT_W-1:0]  n;
  logic              inc;
  logic [MAN_W:0]    r;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (cmb.mag[i]) found = 1'b1;
        else            lz    = lz + LZ_W'(1);
      end
    end

    sh  = '0;
    lim = EXPI_W'(cmb.exp) - EXPI_W'(1);
    if (cmb.mag[EXT_W]) begin
      n = {cmb.mag[EXT_W:2], |cmb.mag[1:0]};
      e = EXPI_W'(cmb.exp) + EXPI_W'(1);
    end else begin
      // never drive the exponent below 1: stop shifting and go subnormal
      sh = (EXPI_W'(lz) < lim) ? EXPI_W'(lz) : lim;
      n  = cmb.mag[EXT_W-1:0] << sh;
      e  = EXPI_W'(cmb.exp) - sh;
    end

    inc = rne & n[GRS_W-1] & ((|n[GRS_W-2:0]) | n[GRS_W]);
    r   = {1'b0, n[EXT_W-1:GRS_W]} + (MAN_W+1)'(inc);
    fld = r[MAN_W] ? (e + EXPI_W'(1)) : (r[MAN_W-1] ? e : '0);

    if (cmb.special)                   word = cmb.spec_word;
    else if (cmb.mag == '0)            word = '0;
    else if (fld >= EXPI_W'(EXP_MAX))  word = {cmb.sign, EXP_MAX, {FRAC_W{1'b0}}};
    else                               word = {cmb.sign, fld[EXP_W-1:0], r[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp32_add_seq.sv
module fp32_add_seq
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rnd_even,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] sum_o,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ALN, ST_ADD, ST_NRM} st_e;

  logic [1:0] rsync;
  logic       rst_sn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_sn = rsync[1];

  st_e   st_q, st_d;
  logic  cap_en, aln_en, cmb_en, res_en;
  word_t opa_q, opb_q, res_d, sum_q;
  logic  rne_q, done_q;
  aln_t  aln_d, aln_q;
  cmb_t  cmb_d, cmb_q;

  assign cap_en = (st_q == ST_IDLE) && start;
  assign aln_en = (st_q == ST_ALN);
  assign cmb_en = (st_q == ST_ADD);
  assign res_en = (st_q == ST_NRM);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_ALN;
      ST_ALN:  st_d = ST_ADD;
      ST_ADD:  st_d = ST_NRM;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      sum_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= res_en;
      if (res_en) sum_q <= res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      opa_q <= op_a;
      opb_q <= op_b;
      rne_q <= rnd_even;
    end
    if (aln_en) aln_q <= aln_d;
    if (cmb_en) cmb_q <= cmb_d;
  end

  fpa_align   u_align   (.op_a(opa_q), .op_b(opb_q), .aln(aln_d));
  fpa_combine u_combine (.aln(aln_q), .cmb(cmb_d));
  fpa_round   u_round   (.cmb(cmb_q), .rne(rne_q), .word(res_d));

  assign sum_o = sum_q;
  assign done  = done_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> $past((st_q == ST_IDLE) && start, 4));

  a_r6_nan_out: assert property (@(posedge clk) disable iff (!rst_sn)
    done && (is_nan(opa_q) || is_nan(opb_q)) |-> sum_o == QNAN);

  a_r7_inf_pass: assert property (@(posedge clk) disable iff (!rst_sn)
    done && is_inf(opa_q) && (exp_of(opb_q) != EXP_MAX) |-> sum_o == opa_q);

  a_r9_cancel_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    done && ((opa_q ^ opb_q) == {1'b1, {(WORD_W-1){1'b0}}}) &&
    (exp_of(opa_q) != EXP_MAX) |-> sum_o == '0);
endmodule

// File: tb/test_fp32_add_seq.sv
module test_fp32_add_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, rnd_even, done;
  logic [31:0] op_a, op_b, sum_o;

  fp32_add_seq i_fp32_add_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd_even(rnd_even),
    .op_a(op_a), .op_b(op_b), .sum_o(sum_o), .done(done));

  int checks = 0, fails = 0, cyc = 0, pushed = 0, seen = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] exp_v;
    int          t0;
    string       tag;
  } item_t;
  item_t sbq[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // exact value scaled by 2^149 as a wide signed integer
  function automatic logic signed [299:0] to_fix(logic [31:0] w);
    logic [299:0] m;
    int ee;
    m  = {276'b0, (w[30:23] != 8'h00), w[22:0]};
    ee = (w[30:23] == 8'h00) ? 1 : int'(w[30:23]);
    m  = m << (ee - 1);
    return w[31] ? -$signed(m) : $signed(m);
  endfunction

  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, bit rne);
    logic signed [299:0] s;
    logic [299:0] mag, q, rem, half;
    logic [63:0] pat;
    bit na, nb, ia, ib, sg, up;
    int p, sh;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    ia = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    ib = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    if (na || nb || (ia && ib && (a[31] != b[31]))) return 32'h7FC00000;
    if (ia) return a;
    if (ib) return b;
    if (a[30:0] == 31'd0 && b[30:0] == 31'd0) return {a[31] & b[31], 31'd0};
    s = to_fix(a) + to_fix(b);
    if (s == '0) return 32'h0;
    sg  = s[299];
    mag = sg ? 300'(-s) : 300'(s);
    p = 0;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    if (p <= 23) pat = 64'(mag[30:0]);
    else begin
      sh   = p - 23;
      q    = mag >> sh;
      rem  = mag & ((300'(1) << sh) - 300'(1));
      half = 300'(1) << (sh - 1);
      up   = rne && ((rem > half) || ((rem == half) && q[0]));
      q    = q + 300'(up);
      pat  = (64'(sh) << 23) + q[63:0];
    end
    if (pat >= 64'h7F800000) pat = 64'h7F800000;
    return {sg, pat[30:0]};
  endfunction

  task automatic issue(logic [31:0] a, logic [31:0] b, bit rne, logic [31:0] exp_v, string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; rnd_even = rne; start = 1'b1;
    it.exp_v = exp_v; it.t0 = cyc; it.tag = tag;
    sbq.push_back(it);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic run_m(logic [31:0] a, logic [31:0] b, bit rne, string tag);
    issue(a, b, rne, ref_add(a, b, rne), tag);
  endtask

  // monitor: pop and compare on each completion
  always @(negedge clk) begin
    item_t it;
    if (rst_n && done) begin
      seen++;
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected done, actual %h expected no completion", sum_o);
      end else begin
        it = sbq.pop_front();
        check(sum_o === it.exp_v, it.tag, sum_o, it.exp_v);
        check((cyc - it.t0) == 4, "R10 done latency", 32'(cyc - it.t0), 32'd4);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10: watchdog expired, actual hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  logic [31:0] rs;
  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    rst_n = 1'b1; start = 1'b0; rnd_even = 1'b0; op_a = '0; op_b = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && sum_o === 32'h0, "R11 reset state", {31'd0, done} | sum_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(32'h3F800000, 32'h40000000, 1'b1, 32'h40400000, "R1 hidden bit add");
    issue(32'h41140000, 32'h40940000, 1'b1, 32'h415E0000, "R2 exponent alignment");
    issue(32'h3F800000, 32'hC0400000, 1'b1, 32'hC0000000, "R3 negative result sign");
    issue(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, "R4 carry normalise");
    issue(32'h3F800000, 32'hBF7FFFFF, 1'b1, 32'h33800000, "R4 cancellation normalise");
    issue(32'h3F800000, 32'h33800000, 1'b1, 32'h3F800000, "R5 tie to even stays");
    issue(32'h3F800001, 32'h33800000, 1'b1, 32'h3F800002, "R5 tie to even rounds up");
    issue(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800001, "R5 truncate tie");
    issue(32'h3F800000, 32'h34400000, 1'b1, 32'h3F800002, "R5 round above half");
    issue(32'h3F800000, 32'h34400000, 1'b0, 32'h3F800001, "R5 truncate above half");
    issue(32'hBF800000, 32'hB4400000, 1'b0, 32'hBF800001, "R5 truncate toward zero negative");
    run_m(32'h3F800000, 32'hB3A00000, 1'b0, "R5 truncate with sticky borrow");
    run_m(32'h3F800000, 32'hB3A00000, 1'b1, "R5 round with sticky borrow");
    issue(32'h7F800001, 32'h3F800000, 1'b1, 32'h7FC00000, "R6 NaN operand");
    issue(32'h3F800000, 32'hFFC12345, 1'b0, 32'h7FC00000, "R6 NaN second operand");
    issue(32'hFF800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R6 opposite infinities");
    issue(32'h7F800000, 32'hC2000000, 1'b1, 32'h7F800000, "R7 infinity passes");
    issue(32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, "R7 negative infinities");
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R7 overflow truncate mode");
    issue(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b1, 32'hFF800000, "R7 overflow negative");
    issue(32'h00000001, 32'h00000001, 1'b1, 32'h00000002, "R8 subnormal sum");
    issue(32'h00800000, 32'h80000001, 1'b1, 32'h007FFFFF, "R8 result below normal");
    issue(32'h007FFFFF, 32'h00000001, 1'b0, 32'h00800000, "R8 subnormal into normal");
    issue(32'h80400000, 32'h80400000, 1'b1, 32'h80800000, "R8 negative subnormals");
    issue(32'h40490FDB, 32'hC0490FDB, 1'b1, 32'h00000000, "R9 exact cancellation");
    issue(32'hC0000000, 32'h40000000, 1'b0, 32'h00000000, "R9 cancellation truncate mode");
    issue(32'h80000000, 32'h80000000, 1'b1, 32'h80000000, "R9 two negative zeros");
    issue(32'h00000000, 32'h80000000, 1'b1, 32'h00000000, "R9 mixed zeros");

    // R10: a start during the add stage must be ignored
    begin
      item_t it;
      @(negedge clk);
      op_a = 32'h40000000; op_b = 32'h40000000; rnd_even = 1'b1; start = 1'b1;
      it.exp_v = 32'h40800000; it.t0 = cyc; it.tag = "R10 first request kept";
      sbq.push_back(it); pushed++;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      op_a = 32'h3F800000; op_b = 32'h3F800000; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (sbq.size() != 0) @(negedge clk);
      repeat (8) @(negedge clk);
      check(seen == pushed, "R10 start while busy ignored", 32'(seen), 32'(pushed));
    end

    rs = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = rs;
      if (rs[3:2] != 2'b00) b[30:23] = a[30:23] + {3'b0, rs[9:5]} - 8'd12;
      if (rs[12:10] == 3'b000) a[30:23] = {8{rs[13]}};
      run_m(a, b, rs[14], "R5 random operands");
    end

    repeat (4) @(negedge clk);
    check(seen == pushed, "R10 one done per request", 32'(seen), 32'(pushed));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule